// File: doc/BRIEF.md
# Multi-Mode Compare Timer

An up-counting timer that a processor programs through a small register port. A prescaler divides the clock, and the counter advances by one on every prescaler tick. Each time the counter arrives at the programmed compare value, a match occurs. What the timer does on a match depends on the selected mode. In one-shot mode it stops itself. In periodic mode it reloads and keeps running. In toggle mode it reloads and inverts a square-wave output. In free-running mode it flags the match and carries on counting past it.

A match sets a sticky interrupt flag when interrupts are enabled. The `irq` output follows that flag. Software clears the flag by writing 1 to the status register. Software can also freeze the timer or reset the count.

The run/stop control is a two-state machine. HALT moves to COUNT when software writes the enable bit as 1. COUNT moves to HALT in two cases: software writes the enable bit as 0, or a match occurs in one-shot mode. A software write takes priority over the one-shot stop in the same cycle. The enable bit reads back as the current state.

Top module: `mode_timer`

## Requirements
- R1: After reset, `irq` and `tout` are 0, and the control (address 0), compare (address 1), status (address 2) and counter (address 3) registers all read 0.
- R2: Writing control bit 30 as 1 starts the timer. While it runs, the counter (read at address 3) increases by one per prescaler tick, so with prescale 0 it reads k at k cycles after the enabling write.
- R3: Control bits 7:0 hold a prescale value P. The counter advances once every P+1 clocks, so the first match comes C·(P+1) cycles after the enabling write, where C is the compare value at address 1.
- R4: Mode field control bits 28:27 = 01 selects periodic mode. A match reloads the counter to 0, enable stays 1, and matches repeat every C·(P+1) cycles.
- R5: Mode 00 selects one-shot mode. The first match reloads the counter to 0 and clears the enable bit. The counter then stays at 0 and no further match occurs.
- R6: Control bit 29 is the interrupt enable. A match sets the status flag (status bit 0), and with it `irq`, one cycle later, but only when bit 29 is 1. When bit 29 is 0, `irq` stays 0.
- R7: Writing 1 to status bit 0 clears the flag. If a clear and a match with interrupts enabled fall in the same cycle, the flag stays set.
- R8: Mode 10 selects toggle mode. The counter reloads as in periodic mode, and `tout` inverts on every match, giving a 50% duty square wave with half-period C·(P+1).
- R9: Mode 11 selects free-running mode. A match raises the flag, but the counter keeps counting past the compare value and wraps only at its maximum.
- R10: Writing control bit 30 as 0 stops the timer. The counter and `tout` then hold their values.
- R11: Writing control bit 26 as 1 clears the counter, the prescaler phase and `tout`. The bit itself always reads back 0.
- R12: A compare value of 0 behaves as 1, so a match occurs on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 compare, 2 status, 3 counter |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt output, high while the flag is set |
| tout | output | 1 | Toggle-mode square-wave output |

## Verification
The scoreboard predicts the exact cycle of every interrupt edge from the compare and prescale values. A design that matched one tick early or late, or that ignored the prescaler, would show each rise out of place. The one-shot run checks that no second match appears and that the enable bit reads 0. A timer that kept running would produce an unexpected rise. A clear write is landed on the very edge of a match; a design where the clear wins would drop `irq`. The remaining runs catch a counter that drifts while stopped, a free-running counter that reloads, and a zero compare value that never matches.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_ONESHOT  = 2'b00,
        MODE_PERIODIC = 2'b01,
        MODE_TOGGLE   = 2'b10,
        MODE_FREE     = 2'b11
    } tmr_mode_e;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } tmr_state_e;

    localparam int BIT_EN   = 30;
    localparam int BIT_IE   = 29;
    localparam int BIT_MODE = 27;
    localparam int BIT_SRST = 26;

    localparam logic [1:0] ADDR_CTL  = 2'd0;
    localparam logic [1:0] ADDR_CMP  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;
    localparam logic [1:0] ADDR_CNT  = 2'd3;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);
    logic [PSC_W-1:0] phase_q;

    assign tick = run && (phase_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clr || tick) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int PSC_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              match,
    output logic              ctl_wr,
    output logic              en_wr,
    output logic              srst,
    output logic              ie,
    output tmr_mode_e         mode,
    output logic [PSC_W-1:0]  psc,
    output logic [CNT_W-1:0]  cmp,
    output logic              flag
);
    logic clr_req;

    assign ctl_wr  = wr && (addr == ADDR_CTL);
    assign en_wr   = wdata[BIT_EN];
    assign srst    = ctl_wr && wdata[BIT_SRST];
    assign clr_req = wr && (addr == ADDR_STAT) && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie   <= 1'b0;
            mode <= MODE_ONESHOT;
            psc  <= '0;
        end else if (ctl_wr) begin
            ie   <= wdata[BIT_IE];
            mode <= tmr_mode_e'(wdata[BIT_MODE+1:BIT_MODE]);
            psc  <= wdata[PSC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp <= '0;
        end else if (wr && (addr == ADDR_CMP)) begin
            cmp <= wdata[CNT_W-1:0];
        end
    end

    // a new match outranks a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (match && ie) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             en_wr,
    input  logic             clr,
    input  tmr_mode_e        mode,
    input  logic [CNT_W-1:0] cmp,
    input  logic             tick,
    output logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             match,
    output logic             tout
);
    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cmp_eff;
    logic [CNT_W-1:0] cnt_inc;

    assign cmp_eff = (cmp == '0) ? CNT_W'(1) : cmp;
    assign cnt_inc = cnt + 1'b1;
    assign match   = tick && (cnt_inc == cmp_eff);
    assign run     = (state_q == ST_COUNT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (ctl_wr && en_wr) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (ctl_wr) begin
                    state_d = en_wr ? ST_COUNT : ST_HALT;
                end else if (match && (mode == MODE_ONESHOT)) begin
                    state_d = ST_HALT;
                end
            end
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tout <= 1'b0;
        end else if (clr) begin
            cnt  <= '0;
            tout <= 1'b0;
        end else begin
            if (match && (mode != MODE_FREE)) cnt <= '0;
            else if (tick)                    cnt <= cnt_inc;
            if (match && (mode == MODE_TOGGLE)) tout <= ~tout;
        end
    end
endmodule

// File: rtl/mode_timer.sv
module mode_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int PSC_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              tout
);
    logic             ctl_wr, en_wr, srst, ie, flag;
    logic             run, tick, match;
    tmr_mode_e        mode;
    logic [PSC_W-1:0] psc;
    logic [CNT_W-1:0] cmp, cnt;

    tmr_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .match(match), .ctl_wr(ctl_wr), .en_wr(en_wr),
        .srst(srst), .ie(ie), .mode(mode), .psc(psc), .cmp(cmp), .flag(flag)
    );

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(srst), .div(psc), .tick(tick)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .en_wr(en_wr), .clr(srst),
        .mode(mode), .cmp(cmp), .tick(tick), .run(run), .cnt(cnt),
        .match(match), .tout(tout)
    );

    assign irq = flag;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTL: begin
                reg_rdata[BIT_EN]              = run;
                reg_rdata[BIT_IE]              = ie;
                reg_rdata[BIT_MODE+1:BIT_MODE] = mode;
                reg_rdata[PSC_W-1:0]           = psc;
            end
            ADDR_CMP:  reg_rdata[CNT_W-1:0] = cmp;
            ADDR_STAT: reg_rdata[0]         = flag;
            ADDR_CNT:  reg_rdata[CNT_W-1:0] = cnt;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             match,
    input logic [1:0]       mode,
    input logic             ctl_wr,
    input logic             srst,
    input logic             ie,
    input logic             irq,
    input logic             tout,
    input logic [CNT_W-1:0] cnt
);
    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode == 2'b00 && !ctl_wr) |=> !run);

    // R4
    reload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode != 2'b11 && !srst) |=> (cnt == '0));

    // R6
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && ie) |=> irq);

    // R6
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !(match && ie)) |=> !irq);

    // R8
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode == 2'b10 && !srst) |=> (tout != $past(tout)));

    // R10
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !srst) |=> ($stable(cnt) && $stable(tout)));
endmodule

bind mode_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .match(match), .mode(mode),
    .ctl_wr(ctl_wr), .srst(srst), .ie(ie), .irq(irq), .tout(tout), .cnt(cnt)
);

// File: tb/sim_mode_timer.sv
module sim_mode_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, tout;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int exp_q[$];
    logic prev_irq = 1'b0;
    bit done = 1'b0;

    mode_timer u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .tout(tout)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: every rising irq must match the next predicted cycle
    always @(negedge clk) begin
        if (rst_n && irq && !prev_irq) begin
            if (exp_q.size() == 0) chk(1'b0, "R6 unexpected irq rise", cyc, -1);
            else begin
                int e;
                e = exp_q.pop_front();
                chk(cyc == e, "R3/R4 irq rise cycle", cyc, e);
            end
        end
        prev_irq = irq;
    end

    function automatic logic [31:0] ctlw(input bit en, input bit ie, input logic [1:0] md,
                                         input bit rs, input logic [7:0] p);
        logic [31:0] w;
        w = '0;
        w[30] = en; w[29] = ie; w[28:27] = md; w[26] = rs; w[7:0] = p;
        return w;
    endfunction

    // called at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: start a run, predict n interrupt rises, clear each one
    task automatic drive_run(input logic [1:0] md, input int c, input int p, input int n);
        int c0;
        wr(2'd1, 32'(c));
        wr(2'd0, ctlw(1, 1, md, 1, 8'(p)));
        c0 = cyc;
        for (int k = 1; k <= n; k++) exp_q.push_back(c0 + k * c * (p + 1));
        for (int k = 0; k < n; k++) begin
            while (!irq) @(negedge clk);
            wr(2'd2, 32'd1);
        end
    endtask

    initial begin
        logic [31:0] v, v2;
        int c0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(irq == 0, "R1 irq", irq, 0);
        chk(tout == 0, "R1 tout", tout, 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk(v == 0, "R1 register", v, 0);
        end
        @(negedge clk);

        // R2 counting, R4 periodic, R7 clear
        wr(2'd1, 32'd5);
        wr(2'd0, ctlw(1, 1, 2'b01, 1, 8'd0));
        c0 = cyc;
        for (int k = 1; k <= 3; k++) exp_q.push_back(c0 + 5 * k);
        wait_cyc(c0 + 2);
        rd(2'd3, v);
        chk(v == 2, "R2 counter value", v, 2);
        for (int k = 0; k < 3; k++) begin
            while (!irq) @(negedge clk);
            wr(2'd2, 32'd1);
            chk(irq == 0, "R7 flag cleared", irq, 0);
        end
        rd(2'd0, v);
        chk(v[30] == 1, "R4 enable stays 1", v[30], 1);

        // R10 freeze
        wr(2'd0, ctlw(0, 1, 2'b01, 0, 8'd0));
        rd(2'd3, v);
        idle(6);
        rd(2'd3, v2);
        chk(v2 == v, "R10 counter frozen", v2, v);

        // R11 soft reset
        @(negedge clk);
        wr(2'd0, ctlw(0, 0, 2'b01, 1, 8'd0));
        rd(2'd3, v);
        chk(v == 0, "R11 counter cleared", v, 0);
        rd(2'd0, v);
        chk(v[26] == 0, "R11 bit reads 0", v[26], 0);
        @(negedge clk);

        // R3 prescaler
        drive_run(2'b01, 3, 2, 2);
        wr(2'd0, ctlw(0, 0, 2'b01, 1, 8'd0));

        // R5 one-shot
        drive_run(2'b00, 4, 0, 1);
        idle(20);
        rd(2'd0, v);
        chk(v[30] == 0, "R5 enable cleared", v[30], 0);
        rd(2'd3, v);
        chk(v == 0, "R5 counter at 0", v, 0);
        chk(irq == 0, "R5 no second match", irq, 0);
        @(negedge clk);

        // R6 interrupt disabled
        wr(2'd1, 32'd3);
        wr(2'd0, ctlw(1, 0, 2'b01, 1, 8'd0));
        idle(20);
        chk(irq == 0, "R6 irq stays low with ie=0", irq, 0);
        wr(2'd0, ctlw(0, 0, 2'b01, 1, 8'd0));

        // R8 toggle
        wr(2'd0, ctlw(1, 0, 2'b10, 1, 8'd0));
        c0 = cyc;
        wait_cyc(c0 + 2);  chk(tout == 0, "R8 tout before match", tout, 0);
        wait_cyc(c0 + 3);  chk(tout == 1, "R8 tout first match", tout, 1);
        wait_cyc(c0 + 5);  chk(tout == 1, "R8 tout holds", tout, 1);
        wait_cyc(c0 + 6);  chk(tout == 0, "R8 tout second match", tout, 0);
        wait_cyc(c0 + 9);  chk(tout == 1, "R8 tout third match", tout, 1);
        wr(2'd0, ctlw(0, 0, 2'b10, 0, 8'd0));
        rd(2'd3, v);
        idle(10);
        chk(tout == 1, "R10 tout held", tout, 1);
        rd(2'd3, v2);
        chk(v2 == v, "R10 counter held in toggle", v2, v);
        @(negedge clk);

        // R12 compare of zero
        wr(2'd1, 32'd0);
        wr(2'd0, ctlw(1, 0, 2'b10, 1, 8'd0));
        c0 = cyc;
        wait_cyc(c0 + 1);  chk(tout == 1, "R12 match after one tick", tout, 1);
        wait_cyc(c0 + 2);  chk(tout == 0, "R12 match every tick", tout, 0);
        wr(2'd0, ctlw(0, 0, 2'b10, 1, 8'd0));

        // R9 free-running
        wr(2'd1, 32'd3);
        wr(2'd0, ctlw(1, 1, 2'b11, 1, 8'd0));
        c0 = cyc;
        exp_q.push_back(c0 + 3);
        wait_cyc(c0 + 6);
        rd(2'd3, v);
        chk(v == 6, "R9 counter passes compare", v, 6);
        chk(irq == 1, "R9 flag raised", irq, 1);
        @(negedge clk);
        wr(2'd0, ctlw(0, 1, 2'b11, 1, 8'd0));
        wr(2'd2, 32'd1);

        // R7 set wins over clear
        wr(2'd1, 32'd4);
        wr(2'd0, ctlw(1, 1, 2'b01, 1, 8'd0));
        c0 = cyc;
        exp_q.push_back(c0 + 4);
        wait_cyc(c0 + 7);
        wr(2'd2, 32'd1);
        chk(irq == 1, "R7 set wins", irq, 1);
        wr(2'd0, ctlw(0, 1, 2'b01, 1, 8'd0));
        wr(2'd2, 32'd1);
        chk(irq == 0, "R7 clear after", irq, 0);

        idle(3);
        chk(exp_q.size() == 0, "R4 all predicted rises seen", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule